// File: doc/BRIEF.md
# SCSI Controller General Command Executor

This block carries out the housekeeping commands of a SCSI protocol controller. A command byte written into the command register port is decoded in the same cycle. The block then acts on it at the next clock edge. Four commands are handled: no-operation, FIFO clear, device reset and SCSI bus reset. The top bit of the byte qualifies a command for DMA. For no-operation, that bit turns the command into a copy of the start transfer count into the current transfer count.

The block produces several outputs:
- single-cycle strobes to the data FIFO and to the transfer counter;
- a latched device-wide soft reset;
- a timed SCSI bus reset pulse;
- a sticky reset-interrupt request;
- the disconnected flag of the connection state.

A device reset stays latched until a no-operation command is written. While it is latched, every other command is dropped. The bus reset pulse width is the product of two parameters, `CLK_MHZ` and `PULSE_US`, counted in clock cycles. With the defaults this is a 25 microsecond pulse at 125 MHz.

Top module: `scsi_gencmd_exec`

## Requirements
- R1: Bits [6:0] of `cmd_byte` select the command: 0x00 no-operation, 0x01 clear FIFO, 0x02 reset device, 0x03 reset bus. Bit 7 is the DMA qualifier. Any other value of bits [6:0] changes no output and no state.
- R2: A no-operation with bit 7 clear changes no output and raises no interrupt.
- R3: A no-operation with bit 7 set does two things in the cycle after the write. It raises `count_load` for exactly one cycle, and it makes `cur_count` equal to the `start_count` sampled at the write.
- R4: Clear FIFO (with either value of bit 7) raises `fifo_clear` for exactly one cycle after the write and raises no interrupt.
- R5: From the cycle after the write, a reset-device command has these effects:
  - `dev_reset` is driven high and `disconnected` is set;
  - any bus reset pulse in progress ends;
  - `rst_irq` is cleared;
  - `cur_count` is cleared.
- R6: While `dev_reset` is high, every command other than no-operation is ignored. A no-operation (with either value of bit 7) drops `dev_reset` in the next cycle and performs no count load.
- R7: A reset-bus command drives `bus_rst` high for exactly `CLK_MHZ*PULSE_US` cycles, starting the cycle after the write, and sets `disconnected`.
- R8: `rst_irq` is set in the first cycle of a bus reset pulse unless `irq_dis` was high at the write. It stays set until `irq_ack` is sampled high. A set in the same cycle as an acknowledge wins.
- R9: A reset-bus command written during an active pulse restarts the count. The pulse then ends exactly `CLK_MHZ*PULSE_US` cycles after the last write.
- R10: `conn_est` clears `disconnected` in the next cycle, but only when `bus_rst` and `dev_reset` are both low in the cycle it is sampled. A command that sets `disconnected` in the same cycle takes priority.
- R11: After an asynchronous reset, every output is low except `disconnected`, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_byte | input | 8 | Command byte; bit 7 DMA qualifier, bits [6:0] command |
| start_count | input | CNT_W | Start transfer count value |
| irq_dis | input | 1 | Disables the bus reset interrupt when high |
| irq_ack | input | 1 | Clears the reset interrupt request |
| conn_est | input | 1 | Connection established by the phase sequencer |
| fifo_clear | output | 1 | One-cycle clear strobe to the data FIFO |
| count_load | output | 1 | One-cycle load strobe of the current transfer count |
| cur_count | output | CNT_W | Current transfer count |
| dev_reset | output | 1 | Latched device-wide soft reset |
| bus_rst | output | 1 | SCSI bus reset output |
| rst_irq | output | 1 | Sticky bus reset interrupt request |
| disconnected | output | 1 | Connection state is disconnected |

## Verification
The assertions assume that `cmd_wr`, `irq_ack` and `conn_est` are sampled as single-cycle qualifiers. They also assume that `start_count` and `irq_dis` are stable in the cycle of a write; the pulse-width checks rely on this. The stimulus drives every input one half period before the sampling edge and holds it for a whole cycle. Writes are kept sparse enough that most bus pulses run to their end, while some are cut by restarts or device resets. Bytes are drawn mostly from the four valid codes with a random DMA bit, with a share of arbitrary values to cover undefined codes.

// File: rtl/gencmd_pkg.sv
package gencmd_pkg;

  typedef enum logic [6:0] {
    OP_NOP      = 7'h00,
    OP_CLR_FIFO = 7'h01,
    OP_RST_DEV  = 7'h02,
    OP_RST_BUS  = 7'h03
  } op_e;

  // One decoded action per accepted command write
  typedef struct packed {
    logic rel;   // leave the held device reset
    logic load;  // copy start count into current count
    logic clr;   // clear data FIFO
    logic rdev;  // reset device
    logic rbus;  // reset SCSI bus
  } act_t;

endpackage

// File: rtl/gencmd_decode.sv
module gencmd_decode
  import gencmd_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  input  logic       held,
  output act_t       act
);

  logic [6:0] code;
  logic       dma;

  assign code = cmd_byte[6:0];
  assign dma  = cmd_byte[7];

  always_comb begin
    act = '0;
    if (cmd_wr) begin
      if (held) begin
        // only a no-operation gets through while the device is held
        act.rel = (code == OP_NOP);
      end else begin
        case (code)
          OP_NOP:      act.load = dma;
          OP_CLR_FIFO: act.clr  = 1'b1;
          OP_RST_DEV:  act.rdev = 1'b1;
          OP_RST_BUS:  act.rbus = 1'b1;
          default:     act      = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/gencmd_pulse_timer.sv
module gencmd_pulse_timer #(
  parameter int PULSE_CYC = 3125,
  localparam int TW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic active
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          en;

  assign en = start | abort | act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (abort) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (start) begin
      cnt_d = TW'(PULSE_CYC - 1);
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;

  // Independent run-length tracker for the width checks
  localparam logic [TW:0] RUN_END = (TW+1)'(PULSE_CYC + 1);
  logic [TW:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (start && !abort)  run_q <= (TW+1)'(1);
    else if (act_q)            run_q <= run_q + 1'b1;
  end

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> run_q <= (TW+1)'(PULSE_CYC)); // R9
  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(act_q) && !$past(abort)) |-> run_q == RUN_END); // R7
  AST_PULSE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(start)); // R7

endmodule

// File: rtl/gencmd_state.sv
module gencmd_state
  import gencmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_t             act,
  input  logic [CNT_W-1:0] start_count,
  input  logic             irq_dis,
  input  logic             irq_ack,
  input  logic             conn_est,
  input  logic             bus_active,
  output logic             fifo_clear,
  output logic             count_load,
  output logic [CNT_W-1:0] cur_count,
  output logic             dev_reset,
  output logic             disconnected,
  output logic             rst_irq
);

  logic             clr_q, ld_q, hold_q, disc_q, irq_q;
  logic             hold_d, disc_d, irq_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, hold_en, disc_en, irq_en;

  always_comb begin
    hold_d  = act.rdev;
    hold_en = act.rdev | act.rel;

    cnt_d  = act.rdev ? '0 : start_count;
    cnt_en = act.rdev | act.load;

    disc_en = act.rdev | act.rbus | (conn_est & ~hold_q & ~bus_active);
    disc_d  = act.rdev | act.rbus;

    irq_en = act.rdev | act.rbus | irq_ack;
    if (act.rdev)                 irq_d = 1'b0;
    else if (act.rbus && !irq_dis) irq_d = 1'b1;
    else if (irq_ack)             irq_d = 1'b0;
    else                          irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
      ld_q  <= 1'b0;
    end else begin
      clr_q <= act.clr;
      ld_q  <= act.load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       disc_q <= 1'b1;
    else if (disc_en) disc_q <= disc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign fifo_clear   = clr_q;
  assign count_load   = ld_q;
  assign cur_count    = cnt_q;
  assign dev_reset    = hold_q;
  assign disconnected = disc_q;
  assign rst_irq      = irq_q;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q |-> cnt_q == $past(start_count)); // R3
  AST_CLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> $past(act.clr)); // R4
  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !act.rel) |=> hold_q); // R6
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> !ld_q && !clr_q); // R6
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(act.rbus && !irq_dis)); // R8
  AST_DISC_IN_BUS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |-> disc_q); // R10

endmodule

// File: rtl/scsi_gencmd_exec.sv
module scsi_gencmd_exec
  import gencmd_pkg::*;
#(
  parameter int CLK_MHZ  = 125,
  parameter int PULSE_US = 25,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_byte,
  input  logic [CNT_W-1:0] start_count,
  input  logic             irq_dis,
  input  logic             irq_ack,
  input  logic             conn_est,
  output logic             fifo_clear,
  output logic             count_load,
  output logic [CNT_W-1:0] cur_count,
  output logic             dev_reset,
  output logic             bus_rst,
  output logic             rst_irq,
  output logic             disconnected
);

  localparam int PULSE_CYC = CLK_MHZ * PULSE_US;

  act_t act;
  logic held;
  logic bus_active;

  assign held    = dev_reset;
  assign bus_rst = bus_active;

  gencmd_decode i_decode (
    .cmd_wr   (cmd_wr),
    .cmd_byte (cmd_byte),
    .held     (held),
    .act      (act)
  );

  gencmd_pulse_timer #(
    .PULSE_CYC (PULSE_CYC)
  ) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (act.rbus),
    .abort  (act.rdev),
    .active (bus_active)
  );

  gencmd_state #(
    .CNT_W (CNT_W)
  ) i_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .act          (act),
    .start_count  (start_count),
    .irq_dis      (irq_dis),
    .irq_ack      (irq_ack),
    .conn_est     (conn_est),
    .bus_active   (bus_active),
    .fifo_clear   (fifo_clear),
    .count_load   (count_load),
    .cur_count    (cur_count),
    .dev_reset    (dev_reset),
    .disconnected (disconnected),
    .rst_irq      (rst_irq)
  );

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_byte[6:2] != 5'd0) |=> !fifo_clear && !count_load); // R1
  AST_BUS_ENDS_ON_DEV_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !dev_reset && cmd_byte[6:0] == 7'h02) |=> dev_reset && !bus_rst && !rst_irq); // R5

endmodule

// File: tb/test_scsi_gencmd_exec.sv
module test_scsi_gencmd_exec;

  localparam int CLK_MHZ  = 125;
  localparam int PULSE_US = 1;
  localparam int CNT_W    = 16;
  localparam int P        = CLK_MHZ * PULSE_US;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_wr;
  logic [7:0]       cmd_byte;
  logic [CNT_W-1:0] start_count;
  logic             irq_dis;
  logic             irq_ack;
  logic             conn_est;
  logic             fifo_clear, count_load, dev_reset, bus_rst, rst_irq, disconnected;
  logic [CNT_W-1:0] cur_count;

  always #4 clk = ~clk;

  scsi_gencmd_exec #(
    .CLK_MHZ (CLK_MHZ), .PULSE_US (PULSE_US), .CNT_W (CNT_W)
  ) i_scsi_gencmd_exec (
    .clk (clk), .rst_n (rst_n), .cmd_wr (cmd_wr), .cmd_byte (cmd_byte),
    .start_count (start_count), .irq_dis (irq_dis), .irq_ack (irq_ack),
    .conn_est (conn_est), .fifo_clear (fifo_clear), .count_load (count_load),
    .cur_count (cur_count), .dev_reset (dev_reset), .bus_rst (bus_rst),
    .rst_irq (rst_irq), .disconnected (disconnected)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // expected state
  logic             e_clr, e_ld, e_hold, e_disc, e_irq;
  logic [CNT_W-1:0] e_cnt;
  int               e_rem;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R4 fifo_clear", 32'(fifo_clear), 32'(e_clr));
    check("R3 count_load", 32'(count_load), 32'(e_ld));
    check("R3 cur_count", 32'(cur_count), 32'(e_cnt));
    check("R6 dev_reset", 32'(dev_reset), 32'(e_hold));
    check("R7 bus_rst", 32'(bus_rst), 32'(e_rem > 0));
    check("R8 rst_irq", 32'(rst_irq), 32'(e_irq));
    check("R10 disconnected", 32'(disconnected), 32'(e_disc));
  endtask

  // Reference model of one clock edge, from the requirements
  function automatic void model_step(input logic wr, input logic [7:0] b,
                                     input logic conn, input logic ack);
    logic old_hold, old_bus, set_disc, set_irq;
    old_hold = e_hold;
    old_bus  = (e_rem > 0);
    set_disc = 1'b0;
    set_irq  = 1'b0;
    e_clr = 1'b0;
    e_ld  = 1'b0;
    if (e_rem > 0) e_rem--;
    if (wr) begin
      if (old_hold) begin
        if (b[6:0] == 7'h00) e_hold = 1'b0;
      end else begin
        case (b[6:0])
          7'h00: if (b[7]) begin e_ld = 1'b1; e_cnt = start_count; end
          7'h01: e_clr = 1'b1;
          7'h02: begin e_hold = 1'b1; set_disc = 1'b1; e_rem = 0; e_irq = 1'b0; e_cnt = '0; end
          7'h03: begin e_rem = P; set_disc = 1'b1; set_irq = !irq_dis; end
          default: ;
        endcase
      end
    end
    if (set_irq)  e_irq = 1'b1;
    else if (ack) e_irq = 1'b0;
    if (set_disc) e_disc = 1'b1;
    else if (conn && !old_hold && !old_bus) e_disc = 1'b0;
  endfunction

  // Called at a falling edge; returns at the next falling edge
  task automatic tick(input logic wr = 1'b0, input logic [7:0] b = 8'h00,
                      input logic conn = 1'b0, input logic ack = 1'b0);
    cmd_wr   = wr;
    cmd_byte = b;
    conn_est = conn;
    irq_ack  = ack;
    model_step(wr, b, conn, ack);
    @(posedge clk);
    @(negedge clk);
    cmd_wr   = 1'b0;
    conn_est = 1'b0;
    irq_ack  = 1'b0;
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_wr = 1'b0; cmd_byte = 8'h00; conn_est = 1'b0; irq_ack = 1'b0;
    e_clr = 0; e_ld = 0; e_hold = 0; e_disc = 1; e_irq = 0; e_cnt = '0; e_rem = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h1d5c_a7e3));
    irq_dis = 1'b0;
    start_count = 16'h0000;
    do_reset();

    // R11: reset state
    check("R11 fifo_clear", 32'(fifo_clear), 0);
    check("R11 count_load", 32'(count_load), 0);
    check("R11 dev_reset", 32'(dev_reset), 0);
    check("R11 bus_rst", 32'(bus_rst), 0);
    check("R11 rst_irq", 32'(rst_irq), 0);
    check("R11 disconnected", 32'(disconnected), 1);

    // R10: connection established clears disconnected
    tick(1'b0, 8'h00, 1'b1);
    check("R10 connected", 32'(disconnected), 0);

    // R2: plain no-operation changes nothing
    tick(1'b1, 8'h00);
    check("R2 no effect", {fifo_clear, count_load, bus_rst, rst_irq, disconnected}, 0);

    // R1: undefined codes ignored, bit 7 is only a qualifier
    tick(1'b1, 8'h45);
    check("R1 undefined", {fifo_clear, count_load, dev_reset, bus_rst, rst_irq, disconnected}, 0);
    tick(1'b1, 8'h81);
    check("R1 dma clear", 32'(fifo_clear), 1);
    tick();
    check("R4 strobe one cycle", 32'(fifo_clear), 0);

    // R3: DMA no-operation loads the count
    start_count = 16'h1234;
    tick(1'b1, 8'h80);
    check("R3 load strobe", 32'(count_load), 1);
    check("R3 loaded value", 32'(cur_count), 32'h1234);
    start_count = 16'hbeef;
    tick();
    check("R3 strobe drops", 32'(count_load), 0);
    check("R3 value held", 32'(cur_count), 32'h1234);

    // R7, R8: full-length bus reset pulse with interrupt
    tick(1'b1, 8'h03);
    check("R8 irq at pulse start", 32'(rst_irq), 1);
    check("R7 disconnected", 32'(disconnected), 1);
    n = 1;
    while (bus_rst && n < 4 * P) begin tick(); if (bus_rst) n++; end
    check("R7 pulse width", n, P);
    check("R8 irq sticky", 32'(rst_irq), 1);
    tick(1'b0, 8'h00, 1'b0, 1'b1);
    check("R8 irq ack", 32'(rst_irq), 0);

    // R8: masked interrupt, set wins over ack
    irq_dis = 1'b1;
    tick(1'b1, 8'h83);
    check("R8 masked", 32'(rst_irq), 0);
    irq_dis = 1'b0;
    tick(1'b1, 8'h03, 1'b0, 1'b1);
    check("R8 set beats ack", 32'(rst_irq), 1);

    // R9: rewrite restarts the pulse; R10: conn ignored during pulse
    repeat (40) tick();
    tick(1'b0, 8'h00, 1'b1);
    check("R10 ignored in bus reset", 32'(disconnected), 1);
    tick(1'b1, 8'h03);
    n = 1;
    while (bus_rst && n < 4 * P) begin tick(); if (bus_rst) n++; end
    check("R9 restart width", n, P);

    // R5, R6: device reset held until no-operation
    tick(1'b0, 8'h00, 1'b1);
    tick(1'b1, 8'h03);
    repeat (5) tick();
    tick(1'b1, 8'h02);
    check("R5 held", 32'(dev_reset), 1);
    check("R5 bus aborted", 32'(bus_rst), 0);
    check("R5 irq cleared", 32'(rst_irq), 0);
    check("R5 count cleared", 32'(cur_count), 0);
    check("R5 disconnected", 32'(disconnected), 1);
    tick(1'b1, 8'h01);
    check("R6 clear ignored", 32'(fifo_clear), 0);
    tick(1'b1, 8'h03);
    check("R6 bus ignored", 32'(bus_rst), 0);
    tick(1'b0, 8'h00, 1'b1);
    check("R10 ignored in dev reset", 32'(disconnected), 1);
    start_count = 16'h0777;
    tick(1'b1, 8'h80);
    check("R6 released", 32'(dev_reset), 0);
    check("R6 no load on release", 32'(count_load), 0);

    // Constrained random phase
    for (int i = 0; i < 6000; i++) begin
      logic       wr;
      logic [7:0] b;
      wr = ($urandom % 100) < 6;
      if (($urandom % 10) < 8) b = {1'($urandom), 5'd0, 2'($urandom)};
      else                     b = 8'($urandom);
      if (($urandom % 50) == 0) irq_dis = 1'($urandom);
      if (($urandom % 20) == 0) start_count = CNT_W'($urandom);
      tick(wr, b, ($urandom % 40) == 0, ($urandom % 30) == 0);
    end

    finish_run();
  end

endmodule